// File: doc/BRIEF.md
# Nested-Loop Compute Engine

This block runs a two-level counted loop in hardware, started by a single strobe. When a start pulse arrives while the engine is idle, it captures its operands. An outer counter then walks the values 3 to 104. For each outer value, an inner counter begins at the operand `b` and climbs in steps of 3 for as long as it stays at or below 102.

Every inner pass tests the parity of `a`:

- If `a` holds an odd number of ones, `g` receives `c` modulo the outer count. A shift-and-subtract remainder unit produces this value over several cycles.
- Otherwise, `h` receives the signed maximum of `c`, the outer count and `b`.

When the whole nest has completed, `done` rises. It stays high until the next accepted start.

Top module: `nest_loop_engine`

## Requirements
- R1: An active-low asynchronous reset (`rst_n` low) drives `g`, `h` and `done` to zero immediately, without waiting for a clock edge.
- R2: A high `start` seen at a clock edge while idle captures `a`, `b` and `c` and clears `done` at that edge. While the engine is busy, `start` and changes on `a`, `b` and `c` have no effect on the results.
- R3: The outer count runs from 3 to 104 inclusive. For each outer value, the inner count starts at `b` (taken as signed 16-bit), runs while it is at most 102, and adds 3 after each pass.
- R4: In an inner pass where `a` has an odd number of one bits, `g` becomes `c` (unsigned) modulo the outer count, and `h` is left unchanged. The remainder is formed by repeated shift-and-subtract with no divide or modulo operator. Consequently, a finished run with `b` at most 102 leaves `g` equal to `c` mod 104.
- R5: In an inner pass where `a` has an even number of one bits, `h` becomes the signed maximum of `c`, the outer count and `b`, and `g` is left unchanged. Consequently, a finished run with `b` at most 102 leaves `h` equal to the signed maximum of `c`, 104 and `b`.
- R6: When `b` is greater than 102, no inner pass runs: `g` and `h` keep their prior values and `done` still rises. While idle, `g` and `h` never change.
- R7: `done` rises only after the outer loop has finished, and it holds high until the next accepted start.
- R8: Input `d` has no influence on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a | input | 16 | Parity-select operand |
| b | input | 16 | Inner-loop start value, signed; maximum candidate |
| c | input | 16 | Dividend for the remainder; maximum candidate |
| d | input | 16 | Accepted but unused |
| start | input | 1 | Start strobe, honoured only while idle |
| g | output | 16 | Last remainder result |
| h | output | 16 | Last maximum result |
| done | output | 1 | Loop nest finished |

## Verification
The assertions assume that reset is held low before the first clock edge. They also assume that `b` is the only value that sets how many inner passes run, and that the outer count never leaves its 3-to-105 window.

The stimulus keeps `b` either above 102 or no further below it than -10. This keeps every run, including a deliberately long one with `b` at zero and odd parity, within the cycle budget.

Operand changes and extra start pulses are applied only mid-run. This exercises the point that inputs are ignored while busy, not the capture edge itself.

// File: rtl/nest_loop_engine.sv
module nest_loop_engine #(
  parameter int W       = 16,
  parameter int I_FIRST = 3,
  parameter int I_LIMIT = 105,
  parameter int J_LIMIT = 102,
  parameter int J_STEP  = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  input  logic         start,
  output logic [W-1:0] g,
  output logic [W-1:0] h,
  output logic         done
);
  localparam int IW = $clog2(I_LIMIT + 1);
  localparam int JW = W + 2;
  localparam int CW = $clog2(W);
  localparam logic signed [JW-1:0] JLIM = JW'(J_LIMIT);

  typedef enum logic [1:0] {S_IDLE, S_OUTER, S_INNER, S_MOD} st_t;

  st_t                 st;
  logic [W-1:0]        ra, rc, quo, rem;
  logic signed [W-1:0] rb;
  logic [IW-1:0]       i;
  logic signed [JW-1:0] j;
  logic [CW-1:0]       k;

  logic unused_d;
  assign unused_d = ^d;

  wire odd      = ^ra;
  wire inner_go = (j <= JLIM);

  logic signed [W-1:0] i_s, m1, mx;
  assign i_s = $signed({{(W-IW){1'b0}}, i});
  assign m1  = ($signed(rc) > i_s) ? $signed(rc) : i_s;
  assign mx  = (m1 > rb) ? m1 : rb;

  logic [W:0]   t, iext, diff;
  logic [W-1:0] rem_nx;
  assign t      = {rem, quo[W-1]};
  assign iext   = {{(W+1-IW){1'b0}}, i};
  assign diff   = t - iext;
  assign rem_nx = (t >= iext) ? diff[W-1:0] : t[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      g <= '0; h <= '0; done <= 1'b0;
      ra <= '0; rb <= '0; rc <= '0; quo <= '0; rem <= '0;
      i <= '0; j <= '0; k <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ra <= a; rb <= b; rc <= c;
          i <= IW'(I_FIRST);
          done <= 1'b0;
          st <= S_OUTER;
        end
        S_OUTER: if (i == IW'(I_LIMIT)) begin
          done <= 1'b1;
          st <= S_IDLE;
        end else begin
          j <= {{(JW-W){rb[W-1]}}, rb};
          st <= S_INNER;
        end
        S_INNER: if (inner_go) begin
          if (odd) begin
            rem <= '0;
            quo <= rc;
            k <= CW'(W-1);
            st <= S_MOD;
          end else begin
            h <= mx;
            j <= j + JW'(J_STEP);
          end
        end else begin
          i <= i + 1'b1;
          st <= S_OUTER;
        end
        S_MOD: begin
          rem <= rem_nx;
          quo <= quo << 1;
          if (k == '0) begin
            g <= rem_nx;
            j <= j + JW'(J_STEP);
            st <= S_INNER;
          end else begin
            k <= k - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_I_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> (i >= IW'(I_FIRST) && i <= IW'(I_LIMIT))); // R3
  AST_REM_BELOW_I: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MOD && k == '0) |=> (g < {{(W-IW){1'b0}}, i})); // R4
  AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st == S_IDLE)); // R7
  AST_DONE_AFTER_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(st) == S_OUTER)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st) == S_IDLE) |-> ($stable(g) && $stable(h))); // R6
  AST_BUSY_KEEPS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> ($stable(ra) && $stable(rb) && $stable(rc))); // R2
endmodule

// File: tb/nest_loop_engine_tb.sv
module nest_loop_engine_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] a = '0, b = '0, c = '0, d = '0;
  logic [15:0] g, h;
  logic done;

  always #10 clk = ~clk;

  nest_loop_engine u_dut (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .c(c), .d(d),
                          .start(start), .g(g), .h(h), .done(done));

  int checks = 0, fails = 0, cycles = 0;
  bit aborted = 0;
  logic [15:0] gm = '0, hm = '0;

  always @(posedge clk) cycles++;

  localparam int NV = 9;
  localparam logic [63:0] VEC [NV] = '{
    {16'h0001, 16'd96,   16'd1000,  16'h1111},
    {16'h0003, 16'd100,  16'hFFFB,  16'h2222},
    {16'h0007, 16'd90,   16'hFFFF,  16'h0000},
    {16'h0000, 16'd101,  16'd500,   16'hFFFF},
    {16'h8000, 16'd102,  16'd103,   16'h1234},
    {16'h0005, 16'hFFF6, 16'hFF00,  16'h0BAD},
    {16'h0001, 16'd0,    16'd12345, 16'h5555},
    {16'h0003, 16'd103,  16'd9,     16'h7777},
    {16'h0000, 16'd50,   16'h7FFF,  16'h0001}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    while (!done && !aborted) begin
      @(negedge clk);
      if (cycles > 190000) begin
        aborted = 1;
        checks++; fails++;
        $display("FAIL R7: watchdog expired, actual done=0 expected done=1");
      end
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic logic [15:0] smax(input logic signed [15:0] x, input logic signed [15:0] y);
    return (x > y) ? x : y;
  endfunction

  initial begin
    #5;
    chk("R1 reset g", g, 16'h0);
    chk("R1 reset h", h, 16'h0);
    chk("R1 reset done", {15'b0, done}, 16'h0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV && !aborted; v++) begin
      {a, b, c, d} = VEC[v];
      if ($signed(b) <= 16'sd102) begin
        if (^a) gm = c % 16'd104;
        else    hm = smax(smax($signed(c), 16'sd104), $signed(b));
      end
      pulse_start();
      chk("R2 done cleared on start", {15'b0, done}, 16'h0);
      wait_done();
      chk("R4 R6 R8 g result", g, gm);
      chk("R5 R6 R8 h result", h, hm);
      repeat (3) @(negedge clk);
      chk("R7 done holds", {15'b0, done}, 16'h1);
    end

    if (!aborted) begin
      a = 16'h0001; b = 16'd99; c = 16'd777;
      gm = 16'd49;
      pulse_start();
      repeat (10) @(negedge clk);
      a = 16'h0000; b = 16'd0; c = 16'd5;
      pulse_start();
      chk("R2 busy keeps done low", {15'b0, done}, 16'h0);
      wait_done();
      chk("R2 busy start ignored g", g, gm);
      chk("R2 busy start ignored h", h, hm);
    end

    if (!aborted) begin
      a = 16'h0000; b = 16'd20; c = 16'd4000;
      pulse_start();
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 async reset g", g, 16'h0);
      chk("R1 async reset h", h, 16'h0);
      chk("R1 async reset done", {15'b0, done}, 16'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule